// File: doc/BRIEF.md
# Dual Full-Bridge Gate Dead-Time Controller

This block turns one logic level per bridge leg into a pair of gate enables, one for the high-side switch and one for the low-side switch. There are two channels, and each channel has two legs. A high leg input selects the high-side switch and a low input selects the low-side switch. Whenever the selected side changes, both switches of the leg are first held off for a programmable number of clock cycles. Only then does the new side turn on, so a leg can never short its supply.

Each channel has an active-low shutdown input that releases every switch of that channel, which leaves its outputs floating. A single global force-off input, driven by standby or by protection logic, releases every switch of both channels. The leg inputs, the shutdowns and the force-off all arrive from outside the clock domain. Each passes through a two-stage synchronizer before the leg logic uses it. All control pins are plain levels, so there is no handshake or back-pressure at any edge of the block. The default counts give 200 ns before a high-side turn-on and 180 ns before a low-side turn-on at a 200 MHz clock. That leaves ample margin for leg inputs toggling at 300 kHz.

Top module: `hb_gate_ctrl`

## Requirements
- R1: A leg whose synchronized input is 1 and whose channel is enabled drives its high-side enable (`hi_gate`) to 1 and its low-side enable to 0 once the dead time has run out.
- R2: A leg whose synchronized input is 0 and whose channel is enabled drives its low-side enable (`lo_gate`) to 1 and its high-side enable to 0 once the dead time has run out.
- R3: Before a high-side enable rises, both enables of that leg have been 0 for at least RISE_DT cycles. After an input change from 0 to 1, the high side turns on exactly RISE_DT+3 clock edges after the change.
- R4: Before a low-side enable rises, both enables of that leg have been 0 for at least FALL_DT cycles. After an input change from 1 to 0, the low side turns on exactly FALL_DT+3 edges after the change.
- R5: The high-side and low-side enables of one leg are never 1 in the same cycle.
- R6: If a leg input reverses while its dead time is still running, the interval restarts for the new side. The side that was abandoned never turns on, and the new side turns on its own dead time plus 3 edges after the reversal.
- R7: While `ch_shdn_n[c]` is 0, all four enables of channel c (legs 2c and 2c+1) are 0 whatever their leg inputs do.
- R8: The two channels are independent: input changes and shutdown of one channel leave the enables of the other channel unchanged.
- R9: While `force_off` is 1, all eight enables are 0.
- R10: After reset, after a shutdown release or after a force-off release, all enables of the affected legs stay 0 for a full dead time. The side selected by the input then turns on at the dead time plus 2 edges after the release. During reset all enables are 0.
- R11: A change on `leg_in`, `ch_shdn_n` or `force_off` does not reach the enables before the third rising clock edge after the change. Switches turn off on exactly that third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| leg_in | input | 4 | Leg level inputs; bit 2c+l is leg l of channel c |
| ch_shdn_n | input | 2 | Active-low shutdown, one bit per channel |
| force_off | input | 1 | Global kill; 1 releases every switch |
| hi_gate | output | 4 | High-side gate enable per leg, same indexing as leg_in |
| lo_gate | output | 4 | Low-side gate enable per leg, same indexing as leg_in |

## Verification
The hardest case to reach from the ports is a reversal that lands inside a dead-time window. The bench reaches it by flipping a leg input and then flipping it back ten cycles later, well inside the window. It then confirms that the abandoned side never lights and that the original side returns a full fall dead time after the second flip. The release paths are reached by driving leg inputs to new levels while the channel is shut down or force-off is held. The bench then measures the edge on which the first gate appears after release.

// File: rtl/hb_gate_pkg.sv
package hb_gate_pkg;
  localparam int LEGS_PER_CH = 2;

  typedef enum logic {
    ST_GAP   = 1'b0,
    ST_DRIVE = 1'b1
  } leg_state_e;

  function automatic int max_dt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hb_leg.sv
module hb_leg
  import hb_gate_pkg::*;
#(
  parameter int RISE_DT = 40,
  parameter int FALL_DT = 36
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lvl,
  output logic hi_on,
  output logic lo_on
);
  localparam int MAXDT = max_dt(RISE_DT, FALL_DT);
  localparam int CW    = (MAXDT > 1) ? $clog2(MAXDT) : 1;
  localparam logic [CW-1:0] RISE_LD = CW'(RISE_DT - 1);
  localparam logic [CW-1:0] FALL_LD = CW'(FALL_DT - 1);

  leg_state_e    st;
  logic          side;
  logic [CW-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_GAP;
      side    <= 1'b0;
      gap_cnt <= FALL_LD;
    end else if (!en || (lvl != side)) begin
      // disabled, or a new side requested: all off and the interval restarts
      st      <= ST_GAP;
      side    <= lvl;
      gap_cnt <= lvl ? RISE_LD : FALL_LD;
    end else if (st == ST_GAP) begin
      if (gap_cnt == '0) st <= ST_DRIVE;
      else               gap_cnt <= gap_cnt - 1'b1;
    end
  end

  assign hi_on = (st == ST_DRIVE) &&  side;
  assign lo_on = (st == ST_DRIVE) && !side;
endmodule

// File: rtl/hb_gate_ctrl.sv
module hb_gate_ctrl
  import hb_gate_pkg::*;
#(
  parameter int NUM_CH      = 2,
  parameter int RISE_DT     = 40,
  parameter int FALL_DT     = 36,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH*LEGS_PER_CH-1:0] leg_in,
  input  logic [NUM_CH-1:0]             ch_shdn_n,
  input  logic                          force_off,
  output logic [NUM_CH*LEGS_PER_CH-1:0] hi_gate,
  output logic [NUM_CH*LEGS_PER_CH-1:0] lo_gate
);
  localparam int NLEG = NUM_CH * LEGS_PER_CH;

  logic [NLEG-1:0]   leg_s;
  logic [NUM_CH:0]   ctl_s;
  logic [NUM_CH-1:0] ch_en;

  hb_sync #(.W(NLEG), .STAGES(SYNC_STAGES)) u_leg_sync (
    .clk(clk), .rst_n(rst_n), .d(leg_in), .q(leg_s)
  );

  hb_sync #(.W(NUM_CH + 1), .STAGES(SYNC_STAGES)) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d({force_off, ch_shdn_n}), .q(ctl_s)
  );

  assign ch_en = ctl_s[NUM_CH-1:0] & ~{NUM_CH{ctl_s[NUM_CH]}};

  for (genvar i = 0; i < NLEG; i++) begin : g_leg
    hb_leg #(.RISE_DT(RISE_DT), .FALL_DT(FALL_DT)) u_leg (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ch_en[i / LEGS_PER_CH]),
      .lvl  (leg_s[i]),
      .hi_on(hi_gate[i]),
      .lo_on(lo_gate[i])
    );
  end
endmodule

// File: rtl/hb_gate_ctrl_chk.sv
module hb_gate_ctrl_chk
  import hb_gate_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int RISE_DT = 40,
  parameter int FALL_DT = 36
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CH*LEGS_PER_CH-1:0] leg_in,
  input logic [NUM_CH-1:0]             ch_shdn_n,
  input logic                          force_off,
  input logic [NUM_CH*LEGS_PER_CH-1:0] hi_gate,
  input logic [NUM_CH*LEGS_PER_CH-1:0] lo_gate
);
  localparam int NLEG  = NUM_CH * LEGS_PER_CH;
  localparam int MAXDT = max_dt(RISE_DT, FALL_DT);
  localparam int CW    = $clog2(MAXDT + 2);
  localparam logic [CW-1:0] SAT = CW'(MAXDT + 1);

  logic [CW-1:0] off_cnt [NLEG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NLEG; i++) off_cnt[i] <= '0;
    end else begin
      for (int i = 0; i < NLEG; i++) begin
        if (hi_gate[i] || lo_gate[i]) off_cnt[i] <= '0;
        else if (off_cnt[i] != SAT)   off_cnt[i] <= off_cnt[i] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NLEG; i++) begin : g_leg_chk
    p_no_overlap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_gate[i] && lo_gate[i]));
    p_rise_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hi_gate[i]) |-> (off_cnt[i] >= CW'(RISE_DT)));
    p_fall_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lo_gate[i]) |-> (off_cnt[i] >= CW'(FALL_DT)));
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch_chk
    p_shdn_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_shdn_n[c] && $past(!ch_shdn_n[c]) && $past(!ch_shdn_n[c], 2)
        && $past(!ch_shdn_n[c], 3))
      |-> (hi_gate[c*LEGS_PER_CH +: LEGS_PER_CH] == '0
           && lo_gate[c*LEGS_PER_CH +: LEGS_PER_CH] == '0));
  end

  p_kill_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_off && $past(force_off) && $past(force_off, 2) && $past(force_off, 3))
    |-> (hi_gate == '0 && lo_gate == '0));
endmodule

bind hb_gate_ctrl hb_gate_ctrl_chk #(
  .NUM_CH(NUM_CH), .RISE_DT(RISE_DT), .FALL_DT(FALL_DT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .leg_in(leg_in), .ch_shdn_n(ch_shdn_n),
  .force_off(force_off), .hi_gate(hi_gate), .lo_gate(lo_gate)
);

// File: tb/hb_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_gate_ctrl_tb_top;
  localparam int RDT = 40;
  localparam int FDT = 36;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] leg_in = 4'b0000;
  logic [1:0] ch_shdn_n = 2'b11;
  logic       force_off = 1'b0;
  logic [3:0] hi_gate, lo_gate;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  hb_gate_ctrl #(.NUM_CH(2), .RISE_DT(RDT), .FALL_DT(FDT)) dut_i (
    .clk(clk), .rst_n(rst_n), .leg_in(leg_in), .ch_shdn_n(ch_shdn_n),
    .force_off(force_off), .hi_gate(hi_gate), .lo_gate(lo_gate)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // counts edges until the wanted gate of a leg turns on
  task automatic watch(input int leg, input bit want_hi, output int off_at,
                       output int on_at, output bit overlap, output bit wrong);
    off_at = -1; on_at = -1; overlap = 0; wrong = 0;
    for (int k = 1; k <= 400; k++) begin
      @(posedge clk); @(negedge clk);
      if (hi_gate[leg] && lo_gate[leg]) overlap = 1;
      if (off_at < 0 && !hi_gate[leg] && !lo_gate[leg]) off_at = k;
      if (off_at >= 0 && (want_hi ? lo_gate[leg] : hi_gate[leg])) wrong = 1;
      if (want_hi ? hi_gate[leg] : lo_gate[leg]) begin on_at = k; break; end
    end
  endtask

  task automatic t_reset();
    int off_at, on_at; bit ov, wr;
    edges(3);
    check(hi_gate == 4'b0 && lo_gate == 4'b0, "R10 reset off", {hi_gate, lo_gate}, 0);
    rst_n = 1'b1;
    watch(0, 1'b0, off_at, on_at, ov, wr);
    check(on_at == FDT + 2, "R10 first low after reset", on_at, FDT + 2);
    edges(5);
    check(lo_gate == 4'b1111 && hi_gate == 4'b0, "R2 all low sides", {hi_gate, lo_gate}, 8'h0f);
  endtask

  task automatic t_rise();
    int off_at, on_at; bit ov, wr;
    leg_in[0] = 1'b1;
    watch(0, 1'b1, off_at, on_at, ov, wr);
    check(off_at == 3, "R11 off on third edge", off_at, 3);
    check(on_at == RDT + 3, "R3 rise dead time", on_at, RDT + 3);
    check(!ov, "R5 no overlap rise", ov, 0);
    check(hi_gate[0] && !lo_gate[0], "R1 high side on", {hi_gate[0], lo_gate[0]}, 2);
  endtask

  task automatic t_fall();
    int off_at, on_at; bit ov, wr;
    leg_in[0] = 1'b0;
    watch(0, 1'b0, off_at, on_at, ov, wr);
    check(off_at == 3, "R11 off on third edge fall", off_at, 3);
    check(on_at == FDT + 3, "R4 fall dead time", on_at, FDT + 3);
    check(!ov, "R5 no overlap fall", ov, 0);
    check(lo_gate[0] && !hi_gate[0], "R2 low side on", {hi_gate[0], lo_gate[0]}, 1);
  endtask

  task automatic t_restart();
    int off_at, on_at; bit ov, wr;
    leg_in[1] = 1'b1;
    edges(10);
    check(!hi_gate[1] && !lo_gate[1], "R6 both off in gap", {hi_gate[1], lo_gate[1]}, 0);
    leg_in[1] = 1'b0;
    watch(1, 1'b0, off_at, on_at, ov, wr);
    check(on_at == FDT + 3, "R6 restart interval", on_at, FDT + 3);
    check(!wr, "R6 abandoned side stays off", wr, 0);
  endtask

  task automatic t_shutdown();
    int off_at, on_at; bit ov, wr;
    logic [3:0] snap;
    leg_in[2] = 1'b1;
    edges(RDT + 6);
    snap = {hi_gate[3:2], lo_gate[3:2]};
    check(snap == 4'b0110, "R1 ch1 leg2 high", snap, 4'b0110);
    ch_shdn_n[0] = 1'b0;
    edges(2);
    check(lo_gate[0] == 1'b1, "R11 shutdown not before third edge", lo_gate[0], 1);
    edges(1);
    check(hi_gate[1:0] == 2'b0 && lo_gate[1:0] == 2'b0, "R7 ch0 off", {hi_gate[1:0], lo_gate[1:0]}, 0);
    for (int t = 0; t < 4; t++) begin
      leg_in[1:0] = 2'(t + 1);
      edges(RDT + 6);
      check(hi_gate[1:0] == 2'b0 && lo_gate[1:0] == 2'b0, "R7 ch0 held off", {hi_gate[1:0], lo_gate[1:0]}, 0);
    end
    check({hi_gate[3:2], lo_gate[3:2]} == snap, "R8 ch1 unchanged", {hi_gate[3:2], lo_gate[3:2]}, snap);
    leg_in[1:0] = 2'b01;
    edges(5);
    ch_shdn_n[0] = 1'b1;
    watch(0, 1'b1, off_at, on_at, ov, wr);
    check(on_at == RDT + 2, "R10 release after shutdown", on_at, RDT + 2);
    check(lo_gate[1] && !hi_gate[1], "R10 other leg low after release", {hi_gate[1], lo_gate[1]}, 1);
  endtask

  task automatic t_kill();
    int off_at, on_at; bit ov, wr;
    force_off = 1'b1;
    edges(2);
    check(hi_gate[0] == 1'b1, "R11 kill not before third edge", hi_gate[0], 1);
    edges(1);
    check(hi_gate == 4'b0 && lo_gate == 4'b0, "R9 all off", {hi_gate, lo_gate}, 0);
    leg_in[3] = 1'b1;
    edges(RDT + 10);
    check(hi_gate == 4'b0 && lo_gate == 4'b0, "R9 held off", {hi_gate, lo_gate}, 0);
    force_off = 1'b0;
    watch(3, 1'b1, off_at, on_at, ov, wr);
    check(on_at == RDT + 2, "R10 release after kill", on_at, RDT + 2);
  endtask

  task automatic t_fast_toggle();
    // 300 kHz at 200 MHz: about 333 cycles per half period
    for (int h = 0; h < 4; h++) begin
      leg_in[2] = ~leg_in[2];
      edges(333);
      if (leg_in[2]) check(hi_gate[2] && !lo_gate[2], "R1 fast toggle high", {hi_gate[2], lo_gate[2]}, 2);
      else           check(lo_gate[2] && !hi_gate[2], "R2 fast toggle low", {hi_gate[2], lo_gate[2]}, 1);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_restart();
    t_shutdown();
    t_kill();
    t_fast_toggle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule